// File: doc/BRIEF.md
# UART Xon/Xoff Flow Controller

This block carries in-band software flow control for a UART. It sits between the receiver, the receive FIFO and the transmitter. Each received character is compared with four programmable control characters. Depending on the mode, a match pauses or resumes the local transmitter, and the matched character is kept out of the receive FIFO. In double-character mode two characters must arrive in a row before any action is taken. If the pair is broken, the first character is released to the FIFO together with the character that broke the pair.

The block also compares the receive FIFO fill level with a programmed trigger. When the level crosses the trigger it asks the transmitter to send the two Xoff characters, and when the level comes back down it asks for the two Xon characters. These inserted characters go ahead of normal transmit data.

A special-character mode stores every character in the FIFO as usual. When a character matches the second Xoff register, it also raises a sticky flag. All comparisons see only the low 5 to 8 bits, as set by the programmed word length.

Received characters arrive as single-cycle `rxValid` pulses at least two cycles apart. Any real UART character time meets this.

Top module: `xonflow_ctrl`

## Requirements
- R1: After reset `txPaused`, `insValid`, `specialFlag` and `fifoWrEn` are 0. All four control-character registers are zero, so in special mode a received 0x00 sets the flag.
- R2: A cycle with `regWr`=1 loads `regData` into the register chosen by `regAddr`: 0 = Xon1, 1 = Xon2, 2 = Xoff1, 3 = Xoff2.
- R3: `rxMode` 00 passes every character to the FIFO with no effect on `txPaused`. In single mode (01), a character matching Xoff1 sets `txPaused` and a character matching Xon1 clears it, both one cycle after `rxValid`.
- R4: In double mode (10 or 11), Xoff1 followed at once by Xoff2 sets `txPaused`. Xon1 followed at once by Xon2 clears it. The change appears one cycle after the second character.
- R5: In double mode, if a character matching Xon1 or Xoff1 is followed by one that is not the matching second character, the first character is written to the FIFO one cycle after the second `rxValid`. The second character is written one cycle later. Matching then restarts with the next character.
- R6: A character used as flow control, in single or double mode, is never written to the FIFO. Any other character is written once, with `fifoWrEn`/`fifoWrData` one cycle after its `rxValid`.
- R7: With `autoEn`=1, a `fifoLevel` greater than `trigLevel` requests Xoff1 then Xoff2, once per crossing. A later level below `trigLevel` requests Xon1 then Xon2, once. A level equal to the trigger starts nothing.
- R8: A requested character is shown on `insData` with `insValid`=1 and held until a cycle with `txLoad`=1. `txFifoPop` is `txLoad` gated off while `insValid` or `txPaused` is 1. Inserts are sent even while paused.
- R9: With `specialEn`=1 and `rxMode`=00, a character matching Xoff2 is still written to the FIFO and sets `specialFlag` one cycle after `rxValid`. The flag stays set until a `statusRead` cycle, and a new match in the same cycle wins over the read.
- R10: Comparisons use only the low 5, 6, 7 or 8 bits, for `wordLen` 00, 01, 10, 11. Register bit 0 lines up with character bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Control-character register write strobe |
| regAddr | input | 2 | Register select (0 Xon1, 1 Xon2, 2 Xoff1, 3 Xoff2) |
| regData | input | 8 | Register write data |
| rxMode | input | 2 | 00 off, 01 single, 1x double |
| specialEn | input | 1 | Special-character detect enable |
| autoEn | input | 1 | Automatic Xoff/Xon insertion enable |
| wordLen | input | 2 | Character length 5 to 8 bits |
| trigLevel | input | 6 | Receive FIFO trigger level |
| fifoLevel | input | 6 | Current receive FIFO fill level |
| rxValid | input | 1 | Received character strobe |
| rxData | input | 8 | Received character |
| fifoWrEn | output | 1 | Receive FIFO write strobe |
| fifoWrData | output | 8 | Receive FIFO write data |
| txLoad | input | 1 | Transmitter is loading its next character |
| txPaused | output | 1 | Remote requested transmitter pause |
| txFifoPop | output | 1 | Transmitter may take a character from its FIFO |
| insValid | output | 1 | Flow-control character waiting to be sent |
| insData | output | 8 | Flow-control character to send |
| statusRead | input | 1 | Status read, clears the special flag |
| specialFlag | output | 1 | Special character seen |

## Verification
A wrong hold state in double mode shows as a missing or extra FIFO write, or as a wrongly ordered write, within two cycles of the character that should have closed or broken the pair. A wrong pause bit shows at once on `txPaused` and `txFifoPop`. Broken hysteresis shows as a repeated or missing pair on `insData` the first time the level sits beyond the trigger. The word-length mask is swept over every character value at every length, so any mis-masked bit shows as a wrong `specialFlag` for some character.

// File: rtl/xonflow_pkg.sv
package xonflow_pkg;
  localparam int CHAR_W = 8;
  localparam int MIN_LEN = 5;
  localparam int IDX_XON1 = 0;
  localparam int IDX_XON2 = 1;
  localparam int IDX_XOFF1 = 2;
  localparam int IDX_XOFF2 = 3;
  localparam int NUM_REGS = 4;

  typedef struct packed {
    logic holdLoad;
    logic pendLoad;
    logic wrRx;
    logic wrHeld;
    logic wrPend;
    logic insXon;
    logic insSecond;
  } strobeT;
endpackage

// File: rtl/xonflow_datapath.sv
module xonflow_datapath
  import xonflow_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [CHAR_W-1:0] regData,
  input  logic [1:0]        wordLen,
  input  logic [CHAR_W-1:0] rxData,
  input  strobeT            stb,
  output logic [NUM_REGS-1:0] hit,
  output logic [CHAR_W-1:0] fifoWrData,
  output logic [CHAR_W-1:0] insData
);
  logic [CHAR_W-1:0] xReg [NUM_REGS];
  logic [CHAR_W-1:0] maskV;
  logic [CHAR_W-1:0] heldByte;
  logic [CHAR_W-1:0] pendByte;

  always_comb begin
    for (int i = 0; i < CHAR_W; i++) maskV[i] = (i < MIN_LEN + int'(wordLen));
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) xReg[g] <= '0;
      else if (regWr && regAddr == 2'(g)) xReg[g] <= regData;
    end
    assign hit[g] = ((rxData ^ xReg[g]) & maskV) == '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldByte <= '0;
      pendByte <= '0;
      fifoWrData <= '0;
    end else begin
      if (stb.holdLoad) heldByte <= rxData;
      if (stb.pendLoad) pendByte <= rxData;
      if (stb.wrHeld) fifoWrData <= heldByte;
      else if (stb.wrPend) fifoWrData <= pendByte;
      else if (stb.wrRx) fifoWrData <= rxData;
    end
  end

  always_comb begin
    if (stb.insXon) insData = stb.insSecond ? xReg[IDX_XON2] : xReg[IDX_XON1];
    else insData = stb.insSecond ? xReg[IDX_XOFF2] : xReg[IDX_XOFF1];
  end
endmodule

// File: rtl/xonflow_control.sv
module xonflow_control
  import xonflow_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       rxMode,
  input  logic             specialEn,
  input  logic             autoEn,
  input  logic [LVL_W-1:0] trigLevel,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic             rxValid,
  input  logic [NUM_REGS-1:0] hit,
  input  logic             txLoad,
  input  logic             statusRead,
  output strobeT           stb,
  output logic             fifoWrEn,
  output logic             txPaused,
  output logic             txFifoPop,
  output logic             insValid,
  output logic             specialFlag
);
  logic holdActive, holdIsXoff, pendValid;
  logic insSecond, insXon, xoffSent;
  logic holdStart, startXoff, doPause, doResume, setFlag;
  logic modeSingle, modeDouble;

  assign modeSingle = (rxMode == 2'b01);
  assign modeDouble = rxMode[1];

  always_comb begin
    stb = '0;
    holdStart = 1'b0;
    startXoff = 1'b0;
    doPause = 1'b0;
    doResume = 1'b0;
    setFlag = 1'b0;
    stb.wrPend = pendValid;
    stb.insXon = insXon;
    stb.insSecond = insSecond;
    if (rxValid) begin
      if (modeSingle) begin
        if (hit[IDX_XOFF1]) doPause = 1'b1;
        else if (hit[IDX_XON1]) doResume = 1'b1;
        else stb.wrRx = 1'b1;
      end else if (modeDouble) begin
        if (holdActive) begin
          if (holdIsXoff && hit[IDX_XOFF2]) doPause = 1'b1;
          else if (!holdIsXoff && hit[IDX_XON2]) doResume = 1'b1;
          else begin
            stb.wrHeld = 1'b1;
            stb.pendLoad = 1'b1;
          end
        end else if (hit[IDX_XOFF1]) begin
          holdStart = 1'b1;
          startXoff = 1'b1;
        end else if (hit[IDX_XON1]) begin
          holdStart = 1'b1;
        end else begin
          stb.wrRx = 1'b1;
        end
      end else begin
        stb.wrRx = 1'b1;
        setFlag = specialEn && hit[IDX_XOFF2];
      end
    end
    stb.holdLoad = holdStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdActive <= 1'b0;
      holdIsXoff <= 1'b0;
      pendValid <= 1'b0;
      fifoWrEn <= 1'b0;
      txPaused <= 1'b0;
      specialFlag <= 1'b0;
    end else begin
      fifoWrEn <= stb.wrRx | stb.wrHeld | stb.wrPend;
      pendValid <= stb.pendLoad;
      if (holdStart) begin
        holdActive <= 1'b1;
        holdIsXoff <= startXoff;
      end else if (rxValid) begin
        holdActive <= 1'b0;
      end
      if (doPause) txPaused <= 1'b1;
      else if (doResume) txPaused <= 1'b0;
      if (setFlag) specialFlag <= 1'b1;
      else if (statusRead) specialFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      insValid <= 1'b0;
      insSecond <= 1'b0;
      insXon <= 1'b0;
      xoffSent <= 1'b0;
    end else if (!insValid) begin
      if (autoEn && !xoffSent && fifoLevel > trigLevel) begin
        insValid <= 1'b1;
        insSecond <= 1'b0;
        insXon <= 1'b0;
        xoffSent <= 1'b1;
      end else if (xoffSent && fifoLevel < trigLevel) begin
        insValid <= 1'b1;
        insSecond <= 1'b0;
        insXon <= 1'b1;
        xoffSent <= 1'b0;
      end
    end else if (txLoad) begin
      if (insSecond) insValid <= 1'b0;
      else insSecond <= 1'b1;
    end
  end

  assign txFifoPop = txLoad && !insValid && !txPaused;
endmodule

// File: rtl/xonflow_ctrl.sv
module xonflow_ctrl
  import xonflow_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [CHAR_W-1:0] regData,
  input  logic [1:0]        rxMode,
  input  logic              specialEn,
  input  logic              autoEn,
  input  logic [1:0]        wordLen,
  input  logic [LVL_W-1:0]  trigLevel,
  input  logic [LVL_W-1:0]  fifoLevel,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  output logic              fifoWrEn,
  output logic [CHAR_W-1:0] fifoWrData,
  input  logic              txLoad,
  output logic              txPaused,
  output logic              txFifoPop,
  output logic              insValid,
  output logic [CHAR_W-1:0] insData,
  input  logic              statusRead,
  output logic              specialFlag
);
  strobeT stb;
  logic [NUM_REGS-1:0] hit;

  xonflow_datapath dp_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regData(regData),
    .wordLen(wordLen), .rxData(rxData), .stb(stb), .hit(hit),
    .fifoWrData(fifoWrData), .insData(insData)
  );

  xonflow_control #(.LVL_W(LVL_W)) ctl_i (
    .clk(clk), .rstN(rstN), .rxMode(rxMode), .specialEn(specialEn), .autoEn(autoEn),
    .trigLevel(trigLevel), .fifoLevel(fifoLevel), .rxValid(rxValid), .hit(hit),
    .txLoad(txLoad), .statusRead(statusRead), .stb(stb), .fifoWrEn(fifoWrEn),
    .txPaused(txPaused), .txFifoPop(txFifoPop), .insValid(insValid),
    .specialFlag(specialFlag)
  );
endmodule

// File: rtl/xonflow_chk.sv
module xonflow_chk #(
  parameter int LVL_W = 6
) (
  input logic clk,
  input logic rstN,
  input logic rxValid,
  input logic specialEn,
  input logic fifoWrEn,
  input logic txPaused,
  input logic txFifoPop,
  input logic txLoad,
  input logic insValid,
  input logic [7:0] insData,
  input logic statusRead,
  input logic specialFlag
);
  // R8: a waiting insert holds until the transmitter loads it
  assert_ins_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    insValid && !txLoad |=> insValid && $stable(insData));
  // R8: no FIFO pop while paused
  assert_no_pop_paused_R8: assert property (@(posedge clk) disable iff (!rstN)
    txPaused |-> !txFifoPop);
  // R3: the pause bit moves only after a received character
  assert_pause_by_rx_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txPaused) |-> $past(rxValid));
  // R6: FIFO writes follow a received character or a pending release
  assert_wr_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> $past(rxValid) || $past(fifoWrEn));
  // R9: flag rises only on a character with special detect enabled
  assert_flag_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(specialFlag) |-> $past(rxValid) && $past(specialEn));
  // R9: flag clears only through a status read
  assert_flag_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(specialFlag) |-> $past(statusRead));
endmodule

bind xonflow_ctrl xonflow_chk #(.LVL_W(LVL_W)) chk_i (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .specialEn(specialEn),
  .fifoWrEn(fifoWrEn), .txPaused(txPaused), .txFifoPop(txFifoPop),
  .txLoad(txLoad), .insValid(insValid), .insData(insData),
  .statusRead(statusRead), .specialFlag(specialFlag)
);

// File: tb/xonflow_ctrl_tb.sv
module xonflow_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regData = '0;
  logic [1:0] rxMode = '0;
  logic specialEn = 1'b0;
  logic autoEn = 1'b0;
  logic [1:0] wordLen = 2'b11;
  logic [5:0] trigLevel = 6'd8;
  logic [5:0] fifoLevel = '0;
  logic rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic fifoWrEn;
  logic [7:0] fifoWrData;
  logic txLoad = 1'b0;
  logic txPaused, txFifoPop, insValid;
  logic [7:0] insData;
  logic statusRead = 1'b0;
  logic specialFlag;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic wr1, wr2, flagS;
  logic [7:0] d1, d2;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xonflow_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regData(regData),
    .rxMode(rxMode), .specialEn(specialEn), .autoEn(autoEn), .wordLen(wordLen),
    .trigLevel(trigLevel), .fifoLevel(fifoLevel), .rxValid(rxValid), .rxData(rxData),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .txLoad(txLoad),
    .txPaused(txPaused), .txFifoPop(txFifoPop), .insValid(insValid),
    .insData(insData), .statusRead(statusRead), .specialFlag(specialFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] v);
    regWr = 1'b1; regAddr = a; regData = v;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] b);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    wr1 = fifoWrEn; d1 = fifoWrData; flagS = specialFlag;
    rxValid = 1'b0;
    @(negedge clk);
    wr2 = fifoWrEn; d2 = fifoWrData;
  endtask

  task automatic readStatus();
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  task automatic expectPass(input string req, input logic [7:0] b);
    check(req, {31'd0, wr1}, 1); check(req, {24'd0, d1}, {24'd0, b});
    check(req, {31'd0, wr2}, 0);
  endtask

  task automatic expectNone(input string req);
    check(req, {31'd0, wr1}, 0); check(req, {31'd0, wr2}, 0);
  endtask

  task automatic loadTx(input string req, input logic expPop);
    txLoad = 1'b1;
    #1 check(req, {31'd0, txFifoPop}, {31'd0, expPop});
    @(negedge clk);
    txLoad = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 paused", {31'd0, txPaused}, 0);
    check("R1 insValid", {31'd0, insValid}, 0);
    check("R1 flag", {31'd0, specialFlag}, 0);
    check("R1 fifoWrEn", {31'd0, fifoWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 registers zero: 0x00 matches Xoff2 in special mode (R9)
    specialEn = 1'b1;
    sendRx(8'h00);
    expectPass("R1 zero stored", 8'h00);
    check("R1 zero reg match", {31'd0, flagS}, 1);
    readStatus();
    check("R9 flag cleared", {31'd0, specialFlag}, 0);

    // R2 register writes
    writeReg(2'd0, 8'h11); writeReg(2'd1, 8'h12);
    writeReg(2'd2, 8'h13); writeReg(2'd3, 8'hA5);

    // R10 / R9 sweep of every character at every word length
    for (int wl = 0; wl < 4; wl++) begin
      wordLen = 2'(wl);
      for (int b = 0; b < 256; b++) begin
        logic [7:0] m;
        logic expHit;
        m = 8'((1 << (5 + wl)) - 1);
        expHit = ((8'(b) ^ 8'hA5) & m) == 8'h00;
        sendRx(8'(b));
        check("R9 stored", {23'd0, wr1, d1}, {23'd0, 1'b1, 8'(b)});
        check("R10 masked match", {31'd0, flagS}, {31'd0, expHit});
        if (specialFlag) readStatus();
      end
    end
    // R9 set wins over read in the same cycle
    wordLen = 2'b11;
    rxValid = 1'b1; rxData = 8'hA5; statusRead = 1'b1;
    @(negedge clk);
    rxValid = 1'b0; statusRead = 1'b0;
    check("R9 set beats read", {31'd0, specialFlag}, 1);
    @(negedge clk);
    check("R9 sticky", {31'd0, specialFlag}, 1);
    readStatus();
    specialEn = 1'b0;
    writeReg(2'd3, 8'h14);

    // R3 mode off
    rxMode = 2'b00;
    sendRx(8'h13);
    expectPass("R3 off passes", 8'h13);
    check("R3 off no pause", {31'd0, txPaused}, 0);

    // R3 / R6 single mode
    rxMode = 2'b01;
    sendRx(8'h13);
    expectNone("R6 single xoff consumed");
    check("R3 single pause", {31'd0, txPaused}, 1);
    loadTx("R8 no pop while paused", 1'b0);
    sendRx(8'h41);
    expectPass("R6 single data", 8'h41);
    sendRx(8'h11);
    expectNone("R6 single xon consumed");
    check("R3 single resume", {31'd0, txPaused}, 0);
    loadTx("R8 pop when free", 1'b1);

    // R4 double mode
    rxMode = 2'b10;
    sendRx(8'h13);
    expectNone("R4 xoff1 held");
    check("R4 not yet paused", {31'd0, txPaused}, 0);
    sendRx(8'h14);
    expectNone("R6 xoff pair consumed");
    check("R4 pair pause", {31'd0, txPaused}, 1);
    sendRx(8'h11);
    sendRx(8'h12);
    expectNone("R6 xon pair consumed");
    check("R4 pair resume", {31'd0, txPaused}, 0);

    // R5 broken pairs
    sendRx(8'h13);
    sendRx(8'h41);
    check("R5 first released", {23'd0, wr1, d1}, {23'd0, 1'b1, 8'h13});
    check("R5 second released", {23'd0, wr2, d2}, {23'd0, 1'b1, 8'h41});
    check("R5 no pause", {31'd0, txPaused}, 0);
    sendRx(8'h11);
    sendRx(8'h13);
    check("R5 xon1 released", {23'd0, wr1, d1}, {23'd0, 1'b1, 8'h11});
    check("R5 breaker released", {23'd0, wr2, d2}, {23'd0, 1'b1, 8'h13});
    sendRx(8'h14);
    expectPass("R5 restart", 8'h14);
    check("R5 restart no pause", {31'd0, txPaused}, 0);

    // R7 / R8 automatic insertion
    rxMode = 2'b00;
    autoEn = 1'b1;
    fifoLevel = 6'd8;
    repeat (3) @(negedge clk);
    check("R7 equal no request", {31'd0, insValid}, 0);
    fifoLevel = 6'd9;
    @(negedge clk);
    check("R7 xoff request", {23'd0, insValid, insData}, {23'd0, 1'b1, 8'h13});
    repeat (3) @(negedge clk);
    check("R8 held", {23'd0, insValid, insData}, {23'd0, 1'b1, 8'h13});
    loadTx("R8 insert before fifo", 1'b0);
    check("R8 second xoff", {23'd0, insValid, insData}, {23'd0, 1'b1, 8'h14});
    loadTx("R8 insert before fifo", 1'b0);
    check("R8 done", {31'd0, insValid}, 0);
    repeat (3) @(negedge clk);
    check("R7 once per crossing", {31'd0, insValid}, 0);
    loadTx("R8 fifo after insert", 1'b1);
    fifoLevel = 6'd8;
    repeat (2) @(negedge clk);
    check("R7 equal no xon", {31'd0, insValid}, 0);
    fifoLevel = 6'd7;
    @(negedge clk);
    check("R7 xon request", {23'd0, insValid, insData}, {23'd0, 1'b1, 8'h11});
    loadTx("R8 xon first", 1'b0);
    check("R8 second xon", {23'd0, insValid, insData}, {23'd0, 1'b1, 8'h12});
    loadTx("R8 xon second", 1'b0);
    repeat (2) @(negedge clk);
    check("R7 xon once", {31'd0, insValid}, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule